// File: doc/BRIEF.md
# Alarm, Timer and Periodic Interrupt Unit

This block raises a single active-low interrupt request for a real-time clock from three event sources: a date/time alarm comparator, an elapsed-time counter that rolls over after one day, and a periodic pulse source. All three are evaluated only on the 10 ms update strobe. The calendar itself sits outside; this unit receives the current clock fields in packed BCD and the alarm settings from the status register file.

Each source has an enable, a sticky flag and a mask. A flag is set by its event and stays set until software writes a clear for it. The interrupt line is the OR of the flags whose masks are set. During standby only the alarm can pull the line low; the elapsed-time counter keeps counting and may still record its rollover, and the pulse source is held off.

The elapsed-time counter can be loaded in one cycle with a BCD value, standing in for the transfer from the register file into the counter, and its current value is visible at an output.

Top module: `evt_irq_unit`

## Requirements
- R1: When `alm_en_i` is high and every compared alarm field equals the matching clock field on a cycle with `tick_i` high, `flags_o[1]` (alarm) is set at that clock edge. Field order in both 40-bit buses: byte 0 hundredths, byte 1 seconds, byte 2 minutes, byte 3 hours, byte 4 date.
- R2: An alarm byte equal to 8'hFF is a wildcard and is left out of the comparison.
- R3: With `tmr_en_i` high the counter advances one hundredth per tick in BCD (`tmr_val_o` byte 0 hundredths 00-99, byte 1 seconds 00-59, byte 2 minutes 00-59, byte 3 hours 00-23); `tmr_load_i` loads `tmr_load_val_i` and takes priority over a tick; stepping from 23:59:59.99 wraps to all zeros and sets `flags_o[2]` (timer); with no tick, or with the enable low and no load, the value holds.
- R4: With `pls_en_i` high, a tick sets `flags_o[0]` (pulse) when `rate_sel_i` is one-hot and the selected rate is due: bit 0 every tick, bit 1 when the hundredths units digit is 0, bit 2 when hundredths is 00, bit 3 when hundredths and seconds are both 00. Zero or several select bits set never set the flag.
- R5: `irq_no` is low exactly when some flag is set together with its mask (`pls_mask_i`, `alm_mask_i`, `tmr_mask_i`); it follows the flags and masks combinationally.
- R6: While `standby_i` is high only an unmasked alarm flag drives `irq_no` low; the timer keeps counting and may still set its flag; the pulse flag is not set.
- R7: Flags are sticky; a high bit in `clr_i` (bit 0 pulse, bit 1 alarm, bit 2 timer) clears that flag at the next edge.
- R8: If a clear and a new event of the same source occur in the same cycle, the flag ends up set.
- R9: The alarm fires on the first tick of a matching period only; further matching ticks do not set the flag again until a tick without a match (or with the alarm disabled) has been seen.
- R10: After reset all flags are 0, the counter is 0 and `irq_no` is high.
- R11: With `alm_en_i` low a matching tick does not set the alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 10 ms update strobe, one cycle wide |
| standby_i | input | 1 | Standby mode |
| clk_fields_i | input | 40 | Current clock fields, packed BCD |
| alm_fields_i | input | 40 | Alarm fields, packed BCD or FFh wildcard |
| alm_en_i | input | 1 | Alarm enable |
| tmr_en_i | input | 1 | Timer enable |
| pls_en_i | input | 1 | Pulse enable |
| alm_mask_i | input | 1 | Alarm interrupt mask (1 = allowed) |
| tmr_mask_i | input | 1 | Timer interrupt mask |
| pls_mask_i | input | 1 | Pulse interrupt mask |
| rate_sel_i | input | 4 | Pulse rate select, one-hot |
| clr_i | input | 3 | Flag clear strobes |
| tmr_load_i | input | 1 | Load the timer |
| tmr_load_val_i | input | 32 | Timer load value, packed BCD |
| tmr_val_o | output | 32 | Current timer value, packed BCD |
| flags_o | output | 3 | Sticky flags: pulse, alarm, timer |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench aims at the timer's last step before and at the day boundary, where a wrong carry chain would wrap at the wrong value or never raise the timer flag. It holds a matching alarm across several ticks and then uses a wildcard to re-enter a match, catching a comparator that re-fires every tick or ignores FFh. It drives clears on the same cycle as events, where a clear-wins priority would silently drop an interrupt, and exercises standby with all three flags set, where leaking timer or pulse requests or pulse flags set in standby would show on `irq_no`. Multi-bit and empty rate selects check that a non-one-hot select cannot produce pulses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned ALM_FIELDS = 5;
  localparam int unsigned TMR_STAGES = 4;
  localparam int unsigned RATE_W     = 4;
  localparam int unsigned SRC_N      = 3;

  localparam int unsigned IDX_PULSE = 0;
  localparam int unsigned IDX_ALARM = 1;
  localparam int unsigned IDX_TIMER = 2;

  localparam logic [FIELD_W-1:0] WILDCARD = 8'hFF;

  // wrap value of each timer stage, packed BCD
  function automatic logic [FIELD_W-1:0] stage_limit(input int unsigned idx);
    case (idx)
      0:       return 8'h99;
      1, 2:    return 8'h59;
      default: return 8'h23;
    endcase
  endfunction
endpackage

// File: rtl/evt_alarm_cmp.sv
module evt_alarm_cmp #(
  parameter int unsigned   N    = 5,
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  WILD = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic [N*W-1:0] now_i,
  input  logic [N*W-1:0] ref_i,
  output logic           hit_o
);
  logic [N-1:0] fld_ok;
  logic         match_now;
  logic         seen_q;

  for (genvar g = 0; g < N; g++) begin : g_fld
    assign fld_ok[g] = (ref_i[g*W +: W] == WILD) || (ref_i[g*W +: W] == now_i[g*W +: W]);
  end

  assign match_now = en_i & (&fld_ok);

  // one flop remembers whether the previous tick already matched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (tick_i) seen_q <= match_now;
  end

  assign hit_o = tick_i & match_now & ~seen_q;
endmodule

// File: rtl/evt_bcd_stage.sv
module evt_bcd_stage #(
  parameter int unsigned  W     = 8,
  parameter logic [W-1:0] LIMIT = 8'h99
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0]   val_q;
  logic [W-1:0]   val_inc;
  logic [NIB-1:0] units;
  logic [NIB-1:0] tens;

  assign units  = val_q[NIB-1:0];
  assign tens   = val_q[W-1:NIB];
  assign wrap_o = inc_i & (val_q == LIMIT);

  always_comb begin
    if (val_q == LIMIT)                 val_inc = '0;
    else if (units >= NIB'(9))          val_inc = {tens + NIB'(1), {NIB{1'b0}}};
    else                                val_inc = {tens, units + NIB'(1)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= val_inc;
  end

  assign val_o = val_q;
endmodule

// File: rtl/evt_bcd_timer.sv
module evt_bcd_timer
  import evt_irq_pkg::*;
#(
  parameter int unsigned STAGES = TMR_STAGES,
  parameter int unsigned W      = FIELD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [STAGES*W-1:0] load_val_i,
  input  logic            count_i,
  output logic [STAGES*W-1:0] val_o,
  output logic            roll_o
);
  logic [STAGES:0] carry;

  assign carry[0] = count_i & ~load_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    evt_bcd_stage #(
      .W     (W),
      .LIMIT (stage_limit(g))
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .load_val_i (load_val_i[g*W +: W]),
      .inc_i      (carry[g]),
      .val_o      (val_o[g*W +: W]),
      .wrap_o     (carry[g+1])
    );
  end

  assign roll_o = carry[STAGES];
endmodule

// File: rtl/evt_pulse_sel.sv
module evt_pulse_sel
  import evt_irq_pkg::*;
#(
  parameter int unsigned W = FIELD_W
) (
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic [RATE_W-1:0] sel_i,
  input  logic [W-1:0]      hsec_i,
  input  logic [W-1:0]      sec_i,
  output logic              fire_o
);
  logic [RATE_W-1:0] due;

  assign due[0] = 1'b1;
  assign due[1] = (hsec_i[W/2-1:0] == '0);
  assign due[2] = (hsec_i == '0);
  assign due[3] = (hsec_i == '0) && (sec_i == '0);

  assign fire_o = tick_i & en_i & ~hold_i & $onehot(sel_i) & (|(sel_i & due));
endmodule

// File: rtl/evt_flag.sv
module evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int unsigned FW  = FIELD_W,
  parameter int unsigned NAF = ALM_FIELDS,
  parameter int unsigned NTS = TMR_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              standby_i,
  input  logic [NAF*FW-1:0] clk_fields_i,
  input  logic [NAF*FW-1:0] alm_fields_i,
  input  logic              alm_en_i,
  input  logic              tmr_en_i,
  input  logic              pls_en_i,
  input  logic              alm_mask_i,
  input  logic              tmr_mask_i,
  input  logic              pls_mask_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic [SRC_N-1:0]  clr_i,
  input  logic              tmr_load_i,
  input  logic [NTS*FW-1:0] tmr_load_val_i,
  output logic [NTS*FW-1:0] tmr_val_o,
  output logic [SRC_N-1:0]  flags_o,
  output logic              irq_no
);
  logic [SRC_N-1:0] evt;
  logic [SRC_N-1:0] flag_q;
  logic             alm_hit;
  logic             tmr_roll;
  logic             pls_fire;
  logic             alm_req;
  logic             run_req;

  evt_alarm_cmp #(
    .N    (NAF),
    .W    (FW),
    .WILD (WILDCARD)
  ) u_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (alm_en_i),
    .now_i  (clk_fields_i),
    .ref_i  (alm_fields_i),
    .hit_o  (alm_hit)
  );

  evt_bcd_timer #(
    .STAGES (NTS),
    .W      (FW)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load_i),
    .load_val_i (tmr_load_val_i),
    .count_i    (tick_i & tmr_en_i),
    .val_o      (tmr_val_o),
    .roll_o     (tmr_roll)
  );

  evt_pulse_sel #(
    .W (FW)
  ) u_pulse (
    .tick_i (tick_i),
    .en_i   (pls_en_i),
    .hold_i (standby_i),
    .sel_i  (rate_sel_i),
    .hsec_i (clk_fields_i[FW-1:0]),
    .sec_i  (clk_fields_i[2*FW-1:FW]),
    .fire_o (pls_fire)
  );

  assign evt[IDX_PULSE] = pls_fire;
  assign evt[IDX_ALARM] = alm_hit;
  assign evt[IDX_TIMER] = tmr_roll;

  for (genvar g = 0; g < SRC_N; g++) begin : g_flag
    evt_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[g]),
      .clr_i  (clr_i[g]),
      .q_o    (flag_q[g])
    );
  end

  // only the alarm path survives standby
  assign alm_req = flag_q[IDX_ALARM] & alm_mask_i;
  assign run_req = (flag_q[IDX_TIMER] & tmr_mask_i) | (flag_q[IDX_PULSE] & pls_mask_i);
  assign irq_no  = ~(alm_req | (~standby_i & run_req));
  assign flags_o = flag_q;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic                  standby_i,
  input logic                  alm_mask_i,
  input logic                  tmr_en_i,
  input logic                  tmr_load_i,
  input logic [RATE_W-1:0]     rate_sel_i,
  input logic [SRC_N-1:0]      clr_i,
  input logic [SRC_N-1:0]      flags_o,
  input logic [TMR_STAGES*FIELD_W-1:0] tmr_val_o,
  input logic                  irq_no
);
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) // R7
    (!tick_i && clr_i == '0) |=> $stable(flags_o));

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) // R7
    (!tick_i) |=> ((flags_o & $past(clr_i)) == '0));

  AST_PULSE_NOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) // R4
    (tick_i && !$onehot(rate_sel_i) && !flags_o[IDX_PULSE]) |=> !flags_o[IDX_PULSE]);

  AST_PULSE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni) // R6
    (tick_i && standby_i && !flags_o[IDX_PULSE]) |=> !flags_o[IDX_PULSE]);

  AST_STANDBY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni) // R6
    (standby_i && !(flags_o[IDX_ALARM] && alm_mask_i)) |-> irq_no);

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) // R5
    (flags_o == '0) |-> irq_no);

  AST_TMR_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (!tick_i && !tmr_load_i) |=> $stable(tmr_val_o));

  AST_TMR_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (!tmr_en_i && !tmr_load_i) |=> $stable(tmr_val_o));
endmodule

bind evt_irq_unit evt_irq_chk u_chk (.*);

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick_i, standby_i;
  logic [4:0][7:0] cf, af;
  logic        alm_en_i, tmr_en_i, pls_en_i;
  logic        alm_mask_i, tmr_mask_i, pls_mask_i;
  logic [3:0]  rate_sel_i;
  logic [2:0]  clr_i;
  logic        tmr_load_i;
  logic [31:0] tmr_load_val_i;
  logic [31:0] tmr_val_o;
  logic [2:0]  flags_o;
  logic        irq_no;

  always #4 clk = ~clk;

  evt_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .standby_i(standby_i),
    .clk_fields_i(cf), .alm_fields_i(af),
    .alm_en_i(alm_en_i), .tmr_en_i(tmr_en_i), .pls_en_i(pls_en_i),
    .alm_mask_i(alm_mask_i), .tmr_mask_i(tmr_mask_i), .pls_mask_i(pls_mask_i),
    .rate_sel_i(rate_sel_i), .clr_i(clr_i), .tmr_load_i(tmr_load_i),
    .tmr_load_val_i(tmr_load_val_i), .tmr_val_o(tmr_val_o),
    .flags_o(flags_o), .irq_no(irq_no)
  );

  int n_chk = 0;
  int n_fail = 0;
  int t_mod = 0;
  int ld_int = 0;
  logic [2:0] ef = 3'b000;
  logic prev_m = 1'b0;
  localparam int DAY_LAST = 8639999;

  function automatic logic [7:0] b2(input int x);
    return {4'(x / 10), 4'(x % 10)};
  endfunction

  function automatic logic [31:0] to_bcd(input int v);
    return {b2(v / 360000), b2((v / 6000) % 60), b2((v / 100) % 60), b2(v % 100)};
  endfunction

  function automatic logic exp_irq(input logic [2:0] f);
    return !((f[1] & alm_mask_i) | (!standby_i & ((f[2] & tmr_mask_i) | (f[0] & pls_mask_i))));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // advance the reference model on the current inputs, then clock once
  task automatic step();
    logic m, a_ev, t_ev, p_ev, m_now;
    m = 1'b1;
    for (int f = 0; f < 5; f++)
      if (af[f] != 8'hFF && af[f] != cf[f]) m = 1'b0;
    m_now = alm_en_i & m;
    a_ev = tick_i & m_now & !prev_m;
    if (tick_i) prev_m = m_now;
    t_ev = 1'b0;
    if (tmr_load_i) t_mod = ld_int;
    else if (tick_i && tmr_en_i) begin
      if (t_mod == DAY_LAST) begin t_mod = 0; t_ev = 1'b1; end
      else t_mod++;
    end
    p_ev = tick_i && pls_en_i && !standby_i && $onehot(rate_sel_i) &&
           (rate_sel_i[0] || (rate_sel_i[1] && cf[0][3:0] == 4'h0) ||
            (rate_sel_i[2] && cf[0] == 8'h00) ||
            (rate_sel_i[3] && cf[0] == 8'h00 && cf[1] == 8'h00));
    ef = (ef & ~clr_i) | {t_ev, a_ev, p_ev};
    @(posedge clk);
    #1;
  endtask

  task automatic load_timer(input int v);
    ld_int = v; tmr_load_val_i = to_bcd(v); tmr_load_i = 1'b1;
    step();
    tmr_load_i = 1'b0;
  endtask

  task automatic clear_all();
    tick_i = 1'b0; clr_i = 3'b111; step(); clr_i = 3'b000;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; tick_i = 1'b0; standby_i = 1'b0;
    cf = '0; af = '1;
    alm_en_i = 1'b0; tmr_en_i = 1'b0; pls_en_i = 1'b0;
    alm_mask_i = 1'b0; tmr_mask_i = 1'b0; pls_mask_i = 1'b0;
    rate_sel_i = 4'b0000; clr_i = 3'b000; tmr_load_i = 1'b0; tmr_load_val_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    chk("R10 flags after reset", 32'(flags_o), 32'h0);
    chk("R10 timer after reset", tmr_val_o, 32'h0);
    chk("R10 irq after reset", 32'(irq_no), 32'h1);

    // timer day boundary
    load_timer(DAY_LAST - 1);
    chk("R3 load", tmr_val_o, 32'h23595998);
    tmr_en_i = 1'b1; tick_i = 1'b1;
    step();
    chk("R3 last step", tmr_val_o, 32'h23595999);
    chk("R3 no early flag", 32'(flags_o[2]), 32'h0);
    step();
    chk("R3 wrap value", tmr_val_o, 32'h0);
    chk("R3 rollover flag", 32'(flags_o[2]), 32'h1);
    tick_i = 1'b0; tmr_mask_i = 1'b1; #1;
    chk("R5 timer irq", 32'(irq_no), 32'h0);
    standby_i = 1'b1; #1;
    chk("R6 timer irq gated", 32'(irq_no), 32'h1);
    standby_i = 1'b0;
    step();
    chk("R7 flag sticky", 32'(flags_o[2]), 32'h1);
    clr_i = 3'b100; step(); clr_i = 3'b000;
    chk("R7 clear timer", 32'(flags_o[2]), 32'h0);
    chk("R5 irq released", 32'(irq_no), 32'h1);

    // clear and rollover in the same cycle
    load_timer(DAY_LAST);
    tick_i = 1'b1; clr_i = 3'b100; step(); clr_i = 3'b000; tick_i = 1'b0;
    chk("R8 set beats clear", 32'(flags_o[2]), 32'h1);
    tmr_en_i = 1'b0; clear_all();

    // alarm
    cf = {8'h15, 8'h07, 8'h56, 8'h34, 8'h12};
    af = cf;
    alm_en_i = 1'b1; tick_i = 1'b1; step(); tick_i = 1'b0;
    chk("R1 alarm match", 32'(flags_o[1]), 32'h1);
    clr_i = 3'b010; step(); clr_i = 3'b000;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    chk("R9 no refire on held match", 32'(flags_o[1]), 32'h0);
    cf[0] = 8'h13; tick_i = 1'b1; step();
    chk("R1 mismatch", 32'(flags_o[1]), 32'h0);
    af[0] = 8'hFF; cf[0] = 8'h14; step(); tick_i = 1'b0;
    chk("R2 wildcard hundredths", 32'(flags_o[1]), 32'h1);
    clear_all();
    alm_en_i = 1'b0; cf[0] = 8'h15; tick_i = 1'b1; step(); tick_i = 1'b0;
    chk("R11 disabled alarm", 32'(flags_o[1]), 32'h0);
    alm_en_i = 1'b1; standby_i = 1'b1; alm_mask_i = 1'b1;
    tick_i = 1'b1; step(); tick_i = 1'b0;
    chk("R6 alarm in standby", 32'(flags_o[1]), 32'h1);
    chk("R6 alarm irq in standby", 32'(irq_no), 32'h0);
    standby_i = 1'b0; alm_en_i = 1'b0; alm_mask_i = 1'b0; clear_all();

    // pulse rates
    pls_en_i = 1'b1; pls_mask_i = 1'b1; tick_i = 1'b1; cf[0] = 8'h00; cf[1] = 8'h00;
    rate_sel_i = 4'b0011; step();
    chk("R4 multiple select", 32'(flags_o[0]), 32'h0);
    rate_sel_i = 4'b0000; step();
    chk("R4 empty select", 32'(flags_o[0]), 32'h0);
    rate_sel_i = 4'b0100; cf[0] = 8'h01; step();
    chk("R4 second not due", 32'(flags_o[0]), 32'h0);
    cf[0] = 8'h00; step();
    chk("R4 second due", 32'(flags_o[0]), 32'h1);
    chk("R5 pulse irq", 32'(irq_no), 32'h0);
    clear_all(); tick_i = 1'b1;
    rate_sel_i = 4'b0010; cf[0] = 8'h20; step();
    chk("R4 100 ms due", 32'(flags_o[0]), 32'h1);
    clear_all(); tick_i = 1'b1;
    rate_sel_i = 4'b1000; cf[0] = 8'h00; cf[1] = 8'h05; step();
    chk("R4 minute not due", 32'(flags_o[0]), 32'h0);
    cf[1] = 8'h00; step();
    chk("R4 minute due", 32'(flags_o[0]), 32'h1);
    clear_all(); tick_i = 1'b1;
    standby_i = 1'b1; rate_sel_i = 4'b0001; step();
    chk("R6 pulse suspended", 32'(flags_o[0]), 32'h0);
    standby_i = 1'b0; tick_i = 1'b0;

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] hs_set [4];
      hs_set = '{8'h00, 8'h10, 8'h50, 8'h99};
      tick_i = ($urandom % 4) != 0;
      standby_i = ($urandom % 8) == 0;
      alm_en_i = $urandom; tmr_en_i = ($urandom % 4) != 0; pls_en_i = $urandom;
      alm_mask_i = $urandom; tmr_mask_i = $urandom; pls_mask_i = $urandom;
      rate_sel_i = (($urandom % 5) == 0) ? 4'($urandom) : 4'(1 << ($urandom % 4));
      clr_i = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
      if (($urandom % 64) == 0) begin
        ld_int = (($urandom % 2) == 0) ? DAY_LAST - int'($urandom % 20) : int'($urandom % 8640000);
        tmr_load_val_i = to_bcd(ld_int); tmr_load_i = 1'b1;
      end else tmr_load_i = 1'b0;
      cf[0] = hs_set[$urandom % 4];
      cf[1] = (($urandom % 2) == 0) ? 8'h00 : 8'h30;
      cf[2] = 8'h01; cf[3] = 8'h09; cf[4] = 8'h20;
      for (int f = 0; f < 5; f++)
        af[f] = (($urandom % 3) == 0) ? 8'hFF : cf[f];
      if (($urandom % 4) == 0) af[0] = hs_set[$urandom % 4];
      step();
      chk("R7 random flags", 32'(flags_o), 32'(ef));
      chk("R5 random irq", 32'(irq_no), 32'(exp_irq(ef)));
      chk("R3 random timer", tmr_val_o, to_bcd(t_mod));
    end
    tmr_load_i = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule